// File: doc/BRIEF.md
# I2C Slave Controller with Address-Window Match

This block is the target side of a two-wire serial bus. It samples the clock and data lines through a synchronizer and finds START and STOP conditions and clock edges. It collects the address byte, or bytes, that follow a START. It can answer to one 7-bit address, to every 7-bit address in a low/high window, to a 10-bit address or 10-bit window, and, when enabled, to the general-call address. After the address is accepted, the block acknowledges it and moves into a receive or a transmit phase, as the read/write bit selects.

Incoming bytes are handed over through a receive holding register with a valid/ready pair. Outgoing bytes are taken from a transmit word with a valid signal and a one-cycle taken pulse. When the block needs data it does not have, it holds the clock line low. This happens when it must send a byte and no transmit byte is offered, or when a byte arrives while the holding register is still full. In software-acknowledge mode, the block raises a decision request for each received data byte and holds the clock until the decision comes back. The decision is either accept or refuse.

The pad logic outside the block turns `scl_hold` and `sda_low` into open-drain pull-downs. It feeds the resolved line levels back on `scl_in` and `sda_in`.

Top module: `i2c_range_slave`

## Requirements
- R1: In 7-bit mode with the window disabled, an address byte whose upper seven bits equal `cfg_addr_lo[6:0]` is acknowledged by pulling SDA low during the ninth clock. Any other address is not acknowledged, and the block then leaves SDA released and delivers no data until the next START.
- R2: With `cfg_range_en`=1 in 7-bit mode, every address a with `cfg_addr_lo[6:0]` <= a <= `cfg_addr_hi[6:0]` is acknowledged. Addresses just outside either bound are not acknowledged.
- R3: The byte 0x00 (address 0 with the write bit) is acknowledged and opens a receive phase when `cfg_gc_en`=1. When `cfg_gc_en`=0 it is not acknowledged, unless the configured address or window itself includes 0.
- R4: In 10-bit mode, a write is addressed by a first byte `11110` + a[9:8] + `0` followed by a second byte a[7:0]. Both bytes are acknowledged only on a match. After a repeated START, the byte `11110` + a[9:8] + `1` is acknowledged and opens a transmit phase only if the same 10-bit address was selected since the last STOP.
- R5: Bit 0 of the address byte chooses the phase: 0 means receive and 1 means transmit. In transmit, bytes are sent MSB first. The block changes SDA only while SCL is low.
- R6: Each received data byte appears on `rx_data` with `rx_valid`=1 before its acknowledge bit. It is held unchanged until the cycle in which `rx_ready`=1.
- R7: If `rx_valid` is still 1 when the eighth bit of a new byte has been received, SCL is held low until the register is drained. The new byte is then stored and acknowledged.
- R8: In transmit, if `tx_valid`=0 when a byte is due, SCL is held low until a byte is offered. `tx_taken` pulses for one cycle in the cycle after a byte is accepted.
- R9: With `cfg_sw_ack`=1, `ack_req` is raised with SCL held low for each received data byte. A reply with `ack_nack`=0 acknowledges and delivers the byte. A reply with `ack_nack`=1 refuses it, and the byte is not delivered.
- R10: In transmit, a master NACK on the ninth bit ends the phase. SDA stays released and no further transmit byte is taken until the next START.
- R11: `stop_flag` pulses for one cycle on every STOP. `pkt_end_flag` pulses for one cycle on a repeated START or a STOP that follows an accepted address.
- R12: If the block releases SDA to send a 1 but samples SDA low at the rising SCL edge, `bit_err_flag` pulses once. The block then releases SDA for the rest of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_hold | output | 1 | Pull SCL low (clock stretch) |
| sda_low | output | 1 | Pull SDA low |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| cfg_range_en | input | 1 | 1 matches the lo..hi window, 0 matches lo only |
| cfg_gc_en | input | 1 | Answer the general-call address |
| cfg_sw_ack | input | 1 | Received data bytes wait for an external ACK decision |
| cfg_addr_lo | input | 10 | Own address, or lower bound of the window |
| cfg_addr_hi | input | 10 | Upper bound of the window |
| tx_data | input | 8 | Next byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_taken | output | 1 | Pulse: offered byte was accepted |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | `rx_data` holds an unread byte |
| rx_ready | input | 1 | Consumer drains `rx_data` |
| ack_req | output | 1 | A received byte awaits an ACK decision |
| ack_valid | input | 1 | Decision present |
| ack_nack | input | 1 | 1 refuses the byte |
| stop_flag | output | 1 | Pulse on STOP |
| pkt_end_flag | output | 1 | Pulse on repeated START or STOP after selection |
| bit_err_flag | output | 1 | Pulse on a transmit bit mismatch |

## Verification
A wrong decision in address decode shows up on the ninth clock of the address byte, as a missing or unexpected SDA pull-down. It also shows as bytes that appear, or never appear, on the receive port. A bit counter or shift register that is off by one corrupts the next received or transmitted byte, so the error is visible within one byte time. A stretch state that is entered wrongly or never left stalls SCL. The master model then hangs at the next rising edge, and the run ends as a failure. A flag logic fault is visible as a pulse count that differs at the next START or STOP.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR2, ST_ACK, ST_RX, ST_RX_DEC,
    ST_TX_LOAD, ST_TX, ST_TX_ACK, ST_WAIT
  } i2cs_state_e;

  localparam int          BYTE_W   = 8;
  localparam logic [4:0]  HDR_TEN  = 5'b11110;

  // 7-bit compare: single address or inclusive window
  function automatic logic hit_7(input logic [6:0] a, input logic [6:0] lo,
                                 input logic [6:0] hi, input logic rng);
    return rng ? ((a >= lo) && (a <= hi)) : (a == lo);
  endfunction

  // 10-bit compare: single address or inclusive window
  function automatic logic hit_10(input logic [9:0] a, input logic [9:0] lo,
                                  input logic [9:0] hi, input logic rng);
    return rng ? ((a >= lo) && (a <= hi)) : (a == lo);
  endfunction

  // upper two bits of a 10-bit address carried in the header byte
  function automatic logic hit_top2(input logic [1:0] t, input logic [9:0] lo,
                                    input logic [9:0] hi, input logic rng);
    return rng ? ((t >= lo[9:8]) && (t <= hi[9:8])) : (t == lo[9:8]);
  endfunction

endpackage

// File: rtl/i2cs_line_mon.sv
module i2cs_line_mon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_in};
      sda_q <= {sda_q[STAGES-2:0], sda_in};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  // R11: a START or STOP is only seen while SCL stays high
  assert_cond_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |-> $past(scl_q[STAGES-1]));
endmodule

// File: rtl/i2cs_addr_dec.sv
module i2cs_addr_dec
  import i2cs_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_q,
  input  logic [1:0]        top2_q,
  input  logic              cfg_range_en,
  input  logic              cfg_gc_en,
  input  logic [9:0]        cfg_addr_lo,
  input  logic [9:0]        cfg_addr_hi,
  output logic              hit7,
  output logic              gc_hit,
  output logic              hdr_hit,
  output logic              full_hit
);
  assign hit7     = hit_7(byte_q[7:1], cfg_addr_lo[6:0], cfg_addr_hi[6:0], cfg_range_en);
  assign gc_hit   = cfg_gc_en && (byte_q == 8'h00);
  assign hdr_hit  = (byte_q[7:3] == HDR_TEN) &&
                    hit_top2(byte_q[2:1], cfg_addr_lo, cfg_addr_hi, cfg_range_en);
  assign full_hit = hit_10({top2_q, byte_q}, cfg_addr_lo, cfg_addr_hi, cfg_range_en);
endmodule

// File: rtl/i2c_range_slave.sv
module i2c_range_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_CYC   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_hold,
  output logic       sda_low,
  input  logic       cfg_ten_bit,
  input  logic       cfg_range_en,
  input  logic       cfg_gc_en,
  input  logic       cfg_sw_ack,
  input  logic [9:0] cfg_addr_lo,
  input  logic [9:0] cfg_addr_hi,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_taken,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic       ack_req,
  input  logic       ack_valid,
  input  logic       ack_nack,
  output logic       stop_flag,
  output logic       pkt_end_flag,
  output logic       bit_err_flag
);
  localparam int CW = $clog2(SETUP_CYC + 1);
  localparam logic [3:0] NBITS = 4'(BYTE_W);

  // bus events
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2cs_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  // state
  i2cs_state_e        st, ack_nxt;
  logic [BYTE_W-1:0]  sh;
  logic [3:0]         cnt;
  logic [1:0]         top2_q;
  logic               ten_sel, sel, m_ack;
  logic [CW-1:0]      setup_q;

  // address decode
  logic hit7, gc_hit, hdr_hit, full_hit;

  i2cs_addr_dec u_dec (
    .byte_q(sh), .top2_q(top2_q), .cfg_range_en(cfg_range_en),
    .cfg_gc_en(cfg_gc_en), .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
    .hit7(hit7), .gc_hit(gc_hit), .hdr_hit(hdr_hit), .full_hit(full_hit)
  );

  // named internal events
  logic        addr_ack, byte_in, dec_ok, dec_nack, load_tx, bit_err_ev;
  i2cs_state_e addr_nxt;

  always_comb begin
    addr_ack = 1'b0;
    addr_nxt = ST_RX;
    if (st == ST_ADDR) begin
      if (cfg_ten_bit) begin
        if (hdr_hit && !sh[0]) begin
          addr_ack = 1'b1; addr_nxt = ST_ADDR2;
        end else if (hdr_hit && sh[0] && ten_sel && (sh[2:1] == top2_q)) begin
          addr_ack = 1'b1; addr_nxt = ST_TX_LOAD;
        end else if (gc_hit) begin
          addr_ack = 1'b1; addr_nxt = ST_RX;
        end
      end else if (hit7) begin
        addr_ack = 1'b1; addr_nxt = sh[0] ? ST_TX_LOAD : ST_RX;
      end else if (gc_hit) begin
        addr_ack = 1'b1; addr_nxt = ST_RX;
      end
    end else if (st == ST_ADDR2) begin
      addr_ack = full_hit;
      addr_nxt = ST_RX;
    end
  end

  assign byte_in    = scl_fall && (cnt == NBITS);
  assign dec_ok     = !rx_valid && (!cfg_sw_ack || ack_valid);
  assign dec_nack   = cfg_sw_ack && ack_nack;
  assign load_tx    = (st == ST_TX_LOAD) && tx_valid;
  assign bit_err_ev = (st == ST_TX) && scl_rise && sh[7] && !sda_s;

  assign ack_req      = (st == ST_RX_DEC) && cfg_sw_ack && !rx_valid;
  assign scl_hold     = (st == ST_TX_LOAD) || (st == ST_RX_DEC) || (setup_q != '0);
  assign sda_low      = (st == ST_ACK) || ((st == ST_TX) && !sh[7]);
  assign stop_flag    = stop_det;
  assign pkt_end_flag = (start_det || stop_det) && sel;
  assign bit_err_flag = bit_err_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ack_nxt  <= ST_RX;
      sh       <= '0;
      cnt      <= '0;
      top2_q   <= '0;
      ten_sel  <= 1'b0;
      sel      <= 1'b0;
      m_ack    <= 1'b0;
      setup_q  <= '0;
      tx_taken <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      tx_taken <= 1'b0;
      if (setup_q != '0) setup_q <= setup_q - 1'b1;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;

      if (stop_det) begin
        st      <= ST_IDLE;
        sel     <= 1'b0;
        ten_sel <= 1'b0;
      end else if (start_det) begin
        st  <= ST_ADDR;
        cnt <= '0;
        sel <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_ADDR2, ST_RX: begin
            if (scl_rise && (cnt < NBITS)) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (byte_in) begin
              if (st == ST_RX) begin
                st <= ST_RX_DEC;
              end else if (addr_ack) begin
                st      <= ST_ACK;
                ack_nxt <= addr_nxt;
                sel     <= 1'b1;
                if (addr_nxt == ST_ADDR2) begin
                  top2_q  <= sh[2:1];
                  ten_sel <= 1'b0;
                end
                if (st == ST_ADDR2) ten_sel <= 1'b1;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              st  <= ack_nxt;
              cnt <= '0;
            end
          end
          ST_RX_DEC: begin
            if (dec_ok) begin
              setup_q <= CW'(SETUP_CYC);
              if (dec_nack) begin
                st <= ST_WAIT;
              end else begin
                rx_data  <= sh;
                rx_valid <= 1'b1;
                st       <= ST_ACK;
                ack_nxt  <= ST_RX;
              end
            end
          end
          ST_TX_LOAD: begin
            if (load_tx) begin
              sh       <= tx_data;
              tx_taken <= 1'b1;
              cnt      <= '0;
              st       <= ST_TX;
              setup_q  <= CW'(SETUP_CYC);
            end
          end
          ST_TX: begin
            if (bit_err_ev) begin
              st <= ST_WAIT;
            end else if (scl_fall) begin
              if (cnt == NBITS - 4'd1) begin
                st <= ST_TX_ACK;
              end else begin
                sh  <= {sh[6:0], 1'b0};
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) m_ack <= !sda_s;
            else if (scl_fall) st <= m_ack ? ST_TX_LOAD : ST_WAIT;
          end
          default: ;
        endcase
      end
    end
  end

  // R8: stretching only ever begins or continues with SCL seen low
  assert_hold_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> !scl_s);

  // R8: a byte is only taken while one was offered
  assert_taken_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_taken |-> $past(tx_valid));

  // R9: a pending ACK decision always keeps SCL stretched
  assert_ackreq_stretch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> scl_hold);

  // R6: an undrained byte stays valid and unchanged
  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R12: after a bit error the data line is released
  assert_err_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err_flag |=> !sda_low);

  // R11: after a STOP the block drives nothing
  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_flag |=> (!sda_low && !ack_req));
endmodule

// File: tb/test_i2c_range_slave.sv
module test_i2c_range_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_hold, sda_low;
  wire  scl_line = m_scl & ~scl_hold;
  wire  sda_line = m_sda & ~sda_low;

  logic       cfg_ten_bit = 0, cfg_range_en = 0, cfg_gc_en = 0, cfg_sw_ack = 0;
  logic [9:0] cfg_addr_lo = 10'h032, cfg_addr_hi = 10'h032;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 0, tx_taken;
  logic [7:0] rx_data;
  logic       rx_valid, rx_ready = 0;
  logic       ack_req, ack_valid = 0, ack_nack = 0;
  logic       stop_flag, pkt_end_flag, bit_err_flag;

  i2c_range_slave i_i2c_range_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_hold(scl_hold), .sda_low(sda_low),
    .cfg_ten_bit(cfg_ten_bit), .cfg_range_en(cfg_range_en), .cfg_gc_en(cfg_gc_en),
    .cfg_sw_ack(cfg_sw_ack), .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_taken(tx_taken),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .ack_req(ack_req), .ack_valid(ack_valid), .ack_nack(ack_nack),
    .stop_flag(stop_flag), .pkt_end_flag(pkt_end_flag), .bit_err_flag(bit_err_flag)
  );

  int vecs = 0, errs = 0;
  int n_stop = 0, n_pkt = 0, n_err = 0, n_ackreq = 0, exp_stop = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  bit auto_rx = 1, cur_nack = 0, prev_scl = 1, prev_sdl = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference side: byte queues, flag counters, per-clock SDA rule
  always @(negedge clk) if (rst_n) begin
    if (stop_flag) n_stop++;
    if (pkt_end_flag) n_pkt++;
    if (bit_err_flag) n_err++;
    if (tx_taken && txq.size() > 0) void'(txq.pop_front());
    tx_valid = (txq.size() > 0);
    tx_data  = (txq.size() > 0) ? txq[0] : 8'h00;
    if (auto_rx && rx_valid && !rx_ready) begin
      if (rxq.size() == 0) chk(0, "R6 unexpected byte", rx_data, 0);
      else chk(rx_data == rxq[0], "R6 rx byte", rx_data, rxq[0]);
      if (rxq.size() > 0) void'(rxq.pop_front());
      rx_ready = 1;
    end else rx_ready = 0;
    if (ack_req && !ack_valid) begin
      n_ackreq++;
      chk(scl_line == 0, "R9 stretch during decision", scl_line, 0);
      ack_valid = 1;
      ack_nack  = cur_nack;
    end else ack_valid = 0;
    if (scl_line && prev_scl)
      chk(sda_low == prev_sdl, "R5 SDA change while SCL high", sda_low, prev_sdl);
    prev_scl = scl_line;
    prev_sdl = sda_low;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic scl_up;
    m_scl = 1;
    while (!scl_line) @(negedge clk);
  endtask
  task automatic do_start;
    m_sda = 1; tick(Q); scl_up; tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q);
  endtask
  task automatic do_stop;
    m_sda = 0; tick(Q); scl_up; tick(Q); m_sda = 1; tick(Q); exp_stop++;
  endtask
  task automatic put_bit(input bit b);
    m_sda = b; tick(Q); scl_up; tick(Q); m_scl = 0; tick(2);
  endtask
  task automatic get_bit(output bit b, input bit force0);
    m_sda = !force0; tick(Q); scl_up; tick(Q); b = sda_line; m_scl = 0; tick(2);
  endtask
  task automatic write_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b, 0);
    ack = !b;
  endtask
  task automatic wr(input logic [7:0] d, input bit exp_ack, input bit is_data, input string req);
    bit a;
    if (is_data && exp_ack) rxq.push_back(d);
    write_byte(d, a);
    chk(a == exp_ack, req, a, exp_ack);
  endtask
  task automatic read_byte(output logic [7:0] d, input bit mack);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b, 0); d[i] = b; end
    put_bit(!mack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [6:0] wa[4];
    bit         we[4];
    bit         b, a;
    int         p0, e0;
    tick(5);
    chk(scl_hold == 0 && sda_low == 0, "R11 reset lines", {scl_hold, sda_low}, 0);
    chk(rx_valid == 0 && tx_taken == 0 && ack_req == 0, "R6 reset", rx_valid, 0);
    rst_n = 1; tick(5);

    // R1 match, two data bytes
    do_start; wr(8'h64, 1, 0, "R1 addr ack");
    wr(8'hA5, 1, 1, "R1 data ack"); wr(8'h3C, 1, 1, "R1 data ack");
    do_stop; tick(4);
    chk(n_pkt == 1, "R11 pkt end after stop", n_pkt, 1);
    chk(rxq.size() == 0, "R6 all delivered", rxq.size(), 0);

    // R1 mismatch: address and following data ignored
    do_start; wr(8'h66, 0, 0, "R1 addr nack"); wr(8'h55, 0, 0, "R1 ignored data");
    do_stop; tick(4);
    chk(n_pkt == 1, "R11 no pkt end when unselected", n_pkt, 1);
    chk(rx_valid == 0, "R1 nothing delivered", rx_valid, 0);

    // R2 window bounds
    cfg_range_en = 1; cfg_addr_lo = 10'h040; cfg_addr_hi = 10'h047;
    wa = '{7'h40, 7'h47, 7'h48, 7'h3F}; we = '{1, 1, 0, 0};
    for (int k = 0; k < 4; k++) begin
      do_start; wr({wa[k], 1'b0}, we[k], 0, "R2 window addr");
      if (we[k]) wr({1'b0, wa[k]}, 1, 1, "R2 window data");
      do_stop;
    end

    // R3 general call
    cfg_range_en = 0; cfg_addr_lo = 10'h032; cfg_addr_hi = 10'h032; cfg_gc_en = 1;
    do_start; wr(8'h00, 1, 0, "R3 gc ack"); wr(8'h99, 1, 1, "R3 gc data"); do_stop;
    cfg_gc_en = 0;
    do_start; wr(8'h00, 0, 0, "R3 gc disabled"); do_stop;

    // R5/R10 transmit, master NACK ends it
    txq = '{8'h9A, 8'h5C, 8'h11};
    do_start; wr(8'h65, 1, 0, "R5 read addr");
    read_byte(d, 1); chk(d == 8'h9A, "R5 tx byte 1", d, 8'h9A);
    read_byte(d, 0); chk(d == 8'h5C, "R10 tx byte 2", d, 8'h5C);
    get_bit(b, 0); chk(b == 1, "R10 SDA released after nack", b, 1);
    chk(txq.size() == 1, "R10 no further byte taken", txq.size(), 1);
    do_stop; txq.delete(); tick(2);

    // R8 stretch on empty transmit
    do_start; wr(8'h65, 1, 0, "R8 read addr");
    fork
      read_byte(d, 0);
      begin
        tick(40);
        chk(scl_hold == 1 && scl_line == 0, "R8 SCL stretched", scl_hold, 1);
        txq.push_back(8'hC3);
      end
    join
    chk(d == 8'hC3, "R8 byte after stretch", d, 8'hC3);
    do_stop;

    // R7 stretch on full receive register
    auto_rx = 0;
    do_start; wr(8'h64, 1, 0, "R7 addr"); wr(8'h12, 1, 1, "R7 first byte");
    rxq.push_back(8'h34);
    fork
      write_byte(8'h34, a);
      begin
        while (!scl_hold) tick(1);
        tick(40);
        chk(scl_hold == 1 && scl_line == 0, "R7 SCL stretched", scl_hold, 1);
        auto_rx = 1;
      end
    join
    chk(a == 1, "R7 ack after drain", a, 1);
    do_stop; tick(4);
    chk(rxq.size() == 0, "R7 both bytes delivered", rxq.size(), 0);

    // R9 software acknowledge
    cfg_sw_ack = 1; n_ackreq = 0;
    do_start; wr(8'h64, 1, 0, "R9 addr");
    cur_nack = 0; wr(8'h11, 1, 1, "R9 accepted byte");
    cur_nack = 1; wr(8'hEE, 0, 0, "R9 refused byte");
    do_stop; tick(4); cfg_sw_ack = 0; cur_nack = 0;
    chk(n_ackreq == 2, "R9 decision requests", n_ackreq, 2);
    chk(rx_valid == 0 && rxq.size() == 0, "R9 refused not delivered", rx_valid, 0);

    // R4 10-bit write, repeated START read
    cfg_ten_bit = 1; cfg_addr_lo = 10'h2A5; cfg_addr_hi = 10'h2A5; p0 = n_pkt;
    do_start; wr(8'hF4, 1, 0, "R4 header"); wr(8'hA5, 1, 0, "R4 low byte");
    wr(8'h77, 1, 1, "R4 data");
    txq.push_back(8'h6D);
    do_start; wr(8'hF5, 1, 0, "R4 read header");
    read_byte(d, 0); chk(d == 8'h6D, "R4 tx byte", d, 8'h6D);
    do_stop; tick(4);
    chk(n_pkt - p0 == 2, "R11 pkt end restart+stop", n_pkt - p0, 2);
    do_start; wr(8'hF4, 1, 0, "R4 header"); wr(8'hA6, 0, 0, "R4 low byte miss"); do_stop;
    do_start; wr(8'hF5, 0, 0, "R4 read without selection"); do_stop;
    do_start; wr(8'hF2, 0, 0, "R4 wrong top bits"); do_stop;

    // R12 bit error
    cfg_ten_bit = 0; cfg_addr_lo = 10'h032; cfg_addr_hi = 10'h032; e0 = n_err;
    txq.push_back(8'hFF);
    do_start; wr(8'h65, 1, 0, "R12 read addr");
    for (int i = 0; i < 8; i++) get_bit(b, i == 2);
    chk(n_err - e0 == 1, "R12 bit error flagged", n_err - e0, 1);
    chk(sda_low == 0, "R12 SDA released", sda_low, 0);
    put_bit(1); do_stop; tick(4);

    chk(n_stop == exp_stop, "R11 stop count", n_stop, exp_stop);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule